// File: doc/BRIEF.md
# Sensor Error Interrupt Controller

This block gathers error events from a hardware-monitor front end and raises a CPU interrupt and a thermal-alarm output. The event sources are two fan counters that exceed their count limit, five supply rails that leave their window, three temperature sensors and a chassis-intrusion switch. Sensor events arrive as one-cycle pulses. The intrusion switch arrives as a level and is edge-detected. Each event sets a sticky bit in one of two status registers. Software reads a status register to see which events fired, and that read clears it.

Two mask registers control the interrupt line. A mask bit at 0 lets its status bit drive the interrupt, and a 1 blocks it. Three further mask bits let a temperature sensor's latched error drive the thermal alarm. They only act while the external global throttling enable is high. The interrupt is produced by a small state machine with states IDLE, ACTIVE and REARM. IDLE goes to ACTIVE when an unmasked status bit is pending. ACTIVE goes to REARM on any read of a status register, and goes to IDLE when nothing unmasked is pending. REARM goes to ACTIVE if work is still pending and to IDLE otherwise. The REARM step makes the line fall for one cycle after each service read, so that remaining errors raise a fresh interrupt edge.

Top module: `sei_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `irq` is low and `therm_alarm` is low.
- R2: The event pulses latch into the status registers at fixed bit positions. Address 0 holds: bit7 `fan_evt[1]`, bit6 `fan_evt[0]`, bit4 `temp_evt[0]`, bits3..0 `volt_evt[3:0]`. Address 1 holds: bit7 `temp_evt[2]`, bit4 intrusion, bit3 `temp_evt[1]`, bit0 `volt_evt[4]`. Reserved bits (address 0 bit5, address 1 bits 6,5,2,1) always read 0.
- R3: A read of address 0 or 1 returns the register contents, with `reg_rdata` valid from the cycle after the strobe, and clears every bit of that register. An event arriving in the same cycle as the clearing read stays set.
- R4: Mask register bits at address 2 and address 3 use the same positions as the status bits. A mask bit of 0 enables the interrupt for its status bit and a 1 disables it. A status bit still latches while it is masked.
- R5: `irq` rises two cycles after an unmasked event pulse is sampled. It stays high until a status read occurs or no unmasked status bit remains.
- R6: While `irq` is high, any status read drops it for exactly one cycle. It then rises again if an unmasked status bit is still set.
- R7: The intrusion bit latches only on a low-to-high transition of `chassis_in`. Holding the input high does not set the bit again after it is cleared.
- R8: `therm_alarm` is high only while `throttle_en` is high and at least one of these pairs holds: status address 0 bit4 set with mask address 2 bit5 clear; status address 1 bit3 set with mask address 3 bit5 clear; status address 1 bit7 set with mask address 3 bit6 clear.
- R9: Mask registers are written with `reg_wr` and read back. Mask address 3 bits 2..1 always read 0.
- R10: Writes to the status addresses 0 and 1 have no effect on their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0,1 status, 2,3 mask |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| fan_evt | input | 2 | Fan count-limit event pulses |
| volt_evt | input | 5 | Rail out-of-window event pulses |
| temp_evt | input | 3 | Temperature error event pulses |
| chassis_in | input | 1 | Intrusion switch level |
| throttle_en | input | 1 | Global throttling enable |
| irq | output | 1 | Interrupt request |
| therm_alarm | output | 1 | Thermal alarm |

## Verification
The hardest situation to reach is the REARM path. It needs unmasked errors pending in both status registers while the line is high, then a read that clears only one of them, and then a check that the line falls for exactly one cycle and rises again. A directed sequence pulses a rail event in each register and waits for the interrupt before reading address 0. Another directed sequence puts an event pulse in the same cycle as a clearing read. The random phase mixes sparse events, reads, mask writes and throttling toggles, so that reads regularly land while the line is high with other work still pending.

// File: rtl/sei_pkg.sv
package sei_pkg;
    localparam int DW = 8;
    localparam int AW = 2;
    localparam int NUM_FAN = 2;
    localparam int NUM_RAIL = 5;
    localparam int NUM_TEMP = 3;

    localparam logic [AW-1:0] A_STS1 = 2'd0;
    localparam logic [AW-1:0] A_STS2 = 2'd1;
    localparam logic [AW-1:0] A_MSK1 = 2'd2;
    localparam logic [AW-1:0] A_MSK2 = 2'd3;

    // bits that may ever be set
    localparam logic [DW-1:0] STS1_LIVE = 8'hDF;
    localparam logic [DW-1:0] STS2_LIVE = 8'h99;
    localparam logic [DW-1:0] MSK2_LIVE = 8'hF9;

    typedef enum logic [1:0] {
        IRQ_IDLE   = 2'd0,
        IRQ_ACTIVE = 2'd1,
        IRQ_REARM  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/sei_status_bank.sv
module sei_status_bank #(
    parameter int W = 8,
    parameter logic [W-1:0] LIVE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q_o[i] <= 1'b0;
                else if (set_i[i])
                    q_o[i] <= 1'b1;
                else if (clr_i)
                    q_o[i] <= 1'b0;
            end
        end else begin : g_rsv
            assign q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sei_irq_fsm.sv
module sei_irq_fsm
    import sei_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pending_i,
    input  logic       ack_i,
    output irq_state_e state_o,
    output logic       irq_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= IRQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   state_d = pending_i ? IRQ_ACTIVE : IRQ_IDLE;
            IRQ_ACTIVE: begin
                if (ack_i)
                    state_d = IRQ_REARM;
                else if (!pending_i)
                    state_d = IRQ_IDLE;
            end
            IRQ_REARM:  state_d = pending_i ? IRQ_ACTIVE : IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o   = (state_q == IRQ_ACTIVE);
        state_o = state_q;
    end
endmodule

// File: rtl/sei_ctrl.sv
module sei_ctrl
    import sei_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       reg_addr,
    input  logic                reg_rd,
    input  logic                reg_wr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [NUM_FAN-1:0]  fan_evt,
    input  logic [NUM_RAIL-1:0] volt_evt,
    input  logic [NUM_TEMP-1:0] temp_evt,
    input  logic                chassis_in,
    input  logic                throttle_en,
    output logic                irq,
    output logic                therm_alarm
);
    logic [DW-1:0] ev1, ev2, sts1, sts2, msk1, msk2;
    logic          chas_prev, chas_rise, clr1, clr2, ack, pending;
    irq_state_e    fsm_state;

    always_ff @(posedge clk) begin
        if (!rst_n) chas_prev <= 1'b0;
        else        chas_prev <= chassis_in;
    end
    assign chas_rise = chassis_in & ~chas_prev;

    assign ev1 = {fan_evt[1], fan_evt[0], 1'b0, temp_evt[0], volt_evt[3:0]};
    assign ev2 = {temp_evt[2], 2'b00, chas_rise, temp_evt[1], 2'b00, volt_evt[4]};

    assign clr1 = reg_rd && (reg_addr == A_STS1);
    assign clr2 = reg_rd && (reg_addr == A_STS2);
    assign ack  = clr1 || clr2;

    sei_status_bank #(.W(DW), .LIVE(STS1_LIVE)) u_sts1 (
        .clk(clk), .rst_n(rst_n), .set_i(ev1), .clr_i(clr1), .q_o(sts1));
    sei_status_bank #(.W(DW), .LIVE(STS2_LIVE)) u_sts2 (
        .clk(clk), .rst_n(rst_n), .set_i(ev2), .clr_i(clr2), .q_o(sts2));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msk1 <= '0;
            msk2 <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_MSK1) msk1 <= reg_wdata;
            if (reg_addr == A_MSK2) msk2 <= reg_wdata & MSK2_LIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd) begin
            unique case (reg_addr)
                A_STS1:  reg_rdata <= sts1;
                A_STS2:  reg_rdata <= sts2;
                A_MSK1:  reg_rdata <= msk1;
                default: reg_rdata <= msk2;
            endcase
        end
    end

    assign pending = |(sts1 & ~msk1) | |(sts2 & ~msk2);

    sei_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pending_i(pending), .ack_i(ack),
        .state_o(fsm_state), .irq_o(irq));

    assign therm_alarm = throttle_en & ((sts1[4] & ~msk1[5]) |
                                        (sts2[3] & ~msk2[5]) |
                                        (sts2[7] & ~msk2[6]));
endmodule

// File: rtl/sei_ctrl_chk.sv
module sei_ctrl_chk
    import sei_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic          reg_rd,
    input logic [DW-1:0] reg_rdata,
    input logic          throttle_en,
    input logic          irq,
    input logic          therm_alarm,
    input logic [DW-1:0] sts1,
    input logic [DW-1:0] sts2,
    input logic [DW-1:0] msk1,
    input logic [DW-1:0] msk2,
    input logic [DW-1:0] ev1,
    input irq_state_e    fsm_state
);
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STS1 && ev1 == '0) |=> (sts1 == '0));

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == A_STS1) |=> ((sts1 & $past(sts1)) == $past(sts1)));

    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(((sts1 & ~msk1) != '0) || ((sts2 & ~msk2) != '0)));

    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == IRQ_ACTIVE && reg_rd && (reg_addr == A_STS1 || reg_addr == A_STS2))
        |=> !irq);

    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !throttle_en |-> !therm_alarm);

    a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_addr == A_STS2) |-> ((reg_rdata & ~STS2_LIVE) == '0));
endmodule

bind sei_ctrl sei_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .throttle_en(throttle_en), .irq(irq),
    .therm_alarm(therm_alarm), .sts1(sts1), .sts2(sts2), .msk1(msk1),
    .msk2(msk2), .ev1(ev1), .fsm_state(fsm_state));

// File: tb/sei_ctrl_bench.sv
module sei_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [1:0] fan_evt = '0;
    logic [4:0] volt_evt = '0;
    logic [2:0] temp_evt = '0;
    logic       chassis_in = 1'b0, throttle_en = 1'b0, irq, therm_alarm;

    int n_tests = 0, n_fail = 0;
    logic [7:0] m_s1 = '0, m_s2 = '0, m_k1 = '0, m_k2 = '0, m_rd = '0;
    logic       m_prev = 1'b0;
    int         m_st = 0; // 0 idle, 1 active, 2 rearm

    always #(CLK_PERIOD/2) clk = ~clk;

    sei_ctrl u_sei_ctrl (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_alarm(input logic thr);
        return thr & ((m_s1[4] & ~m_k1[5]) | (m_s2[3] & ~m_k2[5]) | (m_s2[7] & ~m_k2[6]));
    endfunction

    // one cycle: drive at negedge, update model at edge, check at next negedge
    task automatic cyc(input logic [1:0] f, input logic [4:0] v, input logic [2:0] t,
                       input logic ch, input logic thr, input logic rd, input logic wr,
                       input logic [1:0] a, input logic [7:0] wd, input string tag);
        logic [7:0] e1, e2, n_s1, n_s2, n_k1, n_k2, n_rd;
        logic pend, ack;
        int n_st;
        fan_evt = f; volt_evt = v; temp_evt = t; chassis_in = ch; throttle_en = thr;
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        e1 = {f[1], f[0], 1'b0, t[0], v[3:0]};
        e2 = {t[2], 2'b00, ch & ~m_prev, t[1], 2'b00, v[4]};
        ack = rd && (a < 2);
        pend = ((m_s1 & ~m_k1) != 0) || ((m_s2 & ~m_k2) != 0);
        n_s1 = ((rd && a == 0) ? 8'h00 : m_s1) | e1;
        n_s2 = ((rd && a == 1) ? 8'h00 : m_s2) | e2;
        n_k1 = (wr && a == 2) ? wd : m_k1;
        n_k2 = (wr && a == 3) ? (wd & 8'hF9) : m_k2;
        n_rd = m_rd;
        if (rd) n_rd = (a == 0) ? m_s1 : (a == 1) ? m_s2 : (a == 2) ? m_k1 : m_k2;
        if (m_st == 1) n_st = ack ? 2 : (pend ? 1 : 0);
        else           n_st = pend ? 1 : 0;
        @(posedge clk);
        m_s1 = n_s1; m_s2 = n_s2; m_k1 = n_k1; m_k2 = n_k2; m_rd = n_rd;
        m_st = n_st; m_prev = ch;
        @(negedge clk);
        chk(tag, {7'd0, irq}, {7'd0, m_st == 1});
        chk("R8", {7'd0, therm_alarm}, {7'd0, exp_alarm(thr)});
        chk(tag, reg_rdata, m_rd);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, chassis_in, throttle_en, 0, 0, 0, 0, tag);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        cyc(0, 0, 0, chassis_in, throttle_en, 1, 0, a, 0, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        cyc(0, 0, 0, chassis_in, throttle_en, 0, 1, a, d, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5E1C0DE));
        repeat (3) @(negedge clk);
        chk("R1", {6'd0, irq, therm_alarm}, 8'h00);
        chk("R1", reg_rdata, 8'h00);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) rd(a[1:0], "R1");

        // R2 bit positions and reserved bits
        cyc(2'b01, 5'b00000, 3'b000, 0, 0, 0, 0, 0, 0, "R2");
        cyc(2'b10, 5'b10101, 3'b111, 0, 0, 0, 0, 0, 0, "R2");
        idle(2, "R5");
        rd(0, "R2"); rd(1, "R2"); idle(2, "R2");

        // R4 masked bits latch without interrupt
        wr(2, 8'hFF, "R4");
        cyc(0, 5'b00001, 0, 0, 0, 0, 0, 0, 0, "R4");
        idle(3, "R4");
        rd(0, "R4"); idle(1, "R4");
        wr(2, 8'h00, "R4");

        // R6 re-fire with work left in the other register
        cyc(0, 5'b10001, 0, 0, 0, 0, 0, 0, 0, "R6");
        idle(3, "R6");
        rd(0, "R6"); idle(3, "R6");
        rd(1, "R6"); idle(3, "R6");

        // R3 event in the same cycle as the clearing read
        cyc(0, 5'b00010, 0, 0, 0, 0, 0, 0, 0, "R3");
        idle(2, "R3");
        cyc(2'b10, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
        rd(0, "R3"); rd(0, "R3"); idle(2, "R3");

        // R7 intrusion held high latches once
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R7");
        idle(3, "R7");
        rd(1, "R7"); idle(2, "R7"); rd(1, "R7");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        idle(2, "R7");

        // R8 thermal alarm gating
        cyc(0, 0, 3'b001, 0, 0, 0, 0, 0, 0, "R8");
        idle(2, "R8");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R8");
        wr(2, 8'h20, "R8");
        wr(2, 8'h00, "R8");
        cyc(0, 0, 3'b110, 0, 1, 0, 0, 0, 0, "R8");
        wr(3, 8'h60, "R8");
        idle(2, "R8");
        rd(0, "R8"); rd(1, "R8");
        wr(3, 8'h00, "R8");

        // R9 / R10 register access
        wr(3, 8'hFF, "R9"); rd(3, "R9");
        wr(2, 8'hA5, "R9"); rd(2, "R9");
        wr(0, 8'hFF, "R10"); wr(1, 8'hFF, "R10");
        rd(0, "R10"); rd(1, "R10");
        wr(2, 8'h00, "R9"); wr(3, 8'h00, "R9");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] f; logic [4:0] v; logic [2:0] t;
            logic ch, thr, r, w; logic [1:0] a; logic [7:0] d;
            int op;
            f = 0; v = 0; t = 0;
            for (int b = 0; b < 2; b++) f[b] = ($urandom % 16) == 0;
            for (int b = 0; b < 5; b++) v[b] = ($urandom % 16) == 0;
            for (int b = 0; b < 3; b++) t[b] = ($urandom % 16) == 0;
            ch  = (($urandom % 20) == 0) ? ~chassis_in : chassis_in;
            thr = (($urandom % 10) == 0) ? ~throttle_en : throttle_en;
            op  = $urandom % 8;
            r = (op < 2); w = (op == 2);
            a = $urandom % 4; d = $urandom;
            cyc(f, v, t, ch, thr, r, w, a, d, r ? "R3" : "R5");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule